// File: doc/BRIEF.md
# Privileged Trap and Interrupt Controller

This block decides, once per clock, whether the hart must take a trap and where that trap lands. It takes the pending and enable interrupt vectors, one synchronous exception request, the current privilege level and the status enable bits. From these it picks the trap source and routes it to supervisor or machine level through per-cause delegation masks. It then produces the values the trap CSRs and the program counter take next.

All results are registered, so they appear one clock after the inputs are sampled. The surrounding core applies them when the matching write strobe is high. When the supervisor strobe is high, the core writes the supervisor cause, exception-PC and status fields and clears the supervisor interrupt enable. The machine strobe does the same for the machine registers. Privilege is encoded in 2 bits: user = 0, supervisor = 1, machine = 3. The value 2 is never driven on `cur_priv` and never produced on `next_priv`.

Top module: `trapc_top`

## Requirements
- R1: An interrupt line can be taken only when its bit is set in both `irq_pend` and `irq_en`.
- R2: A line whose `irq_deleg` bit is clear is eligible when `cur_priv` is 0 or 1. At privilege 3 it is eligible only while `st_mie` is 1.
- R3: A line whose `irq_deleg` bit is set is eligible when `cur_priv` is 0, or when `cur_priv` is 1 and `st_sie` is 1. It is never eligible at privilege 3.
- R4: When several lines are eligible, the trap uses the lowest bit index among them.
- R5: An interrupt cause has bit XLEN-1 of `cause_out` set and the line index in the low bits. An exception cause is `exc_code` zero-extended, with bit XLEN-1 clear.
- R6: A trap goes to supervisor level only when all three hold: `cur_priv` is 0 or 1, the cause number is below XLEN, and the matching bit is set in the delegation mask (`irq_deleg` for interrupts, `exc_deleg` for exceptions). Every other trap goes to machine level.
- R7: A supervisor-level trap gives `redirect_pc` = `stvec`, `next_priv` = 1 and `s_csr_wr` = 1.
- R8: A machine-level trap gives `redirect_pc` = `mtvec`, `next_priv` = 3 and `m_csr_wr` = 1.
- R9: On any trap, `epc_out` equals `fault_pc`, and `prev_ie` and `prev_priv` carry the enable bit of the privilege being left (`st_uie`, `st_sie` or `st_mie`) and that privilege itself. The bad-address strobe of the target level is raised only for an exception with `exc_has_bad` = 1, and `badaddr_out` then equals `exc_badaddr`.
- R10: A valid exception takes priority over every interrupt in the same cycle.
- R11: Every trap raises `resv_clear`. Outputs appear one clock after the inputs are sampled. Without a trap, `trap_taken`, all four strobes and `resv_clear` are 0.
- R12: While `rst_n` is low, `trap_taken`, all strobes and `resv_clear` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| st_uie | input | 1 | User interrupt-enable status bit |
| st_sie | input | 1 | Supervisor interrupt-enable status bit |
| st_mie | input | 1 | Machine interrupt-enable status bit |
| irq_pend | input | NIRQ | Pending interrupt lines |
| irq_en | input | NIRQ | Interrupt enable vector |
| irq_deleg | input | NIRQ | Interrupt delegation mask |
| exc_deleg | input | XLEN | Exception delegation mask |
| stvec | input | XLEN | Supervisor trap vector base |
| mtvec | input | XLEN | Machine trap vector base |
| exc_valid | input | 1 | Synchronous exception request |
| exc_code | input | ECW | Exception cause number |
| exc_has_bad | input | 1 | Exception carries a faulting address |
| exc_badaddr | input | XLEN | Faulting address |
| fault_pc | input | XLEN | PC of the trapping instruction |
| trap_taken | output | 1 | A trap was taken |
| redirect_pc | output | XLEN | Next program counter |
| next_priv | output | 2 | Privilege after the trap |
| cause_out | output | XLEN | Value for the cause register |
| epc_out | output | XLEN | Value for the exception-PC register |
| badaddr_out | output | XLEN | Value for the bad-address register |
| s_csr_wr | output | 1 | Write supervisor cause, EPC and status fields |
| m_csr_wr | output | 1 | Write machine cause, EPC and status fields |
| s_bad_wr | output | 1 | Write supervisor bad-address register |
| m_bad_wr | output | 1 | Write machine bad-address register |
| prev_ie | output | 1 | Value for the previous-enable field |
| prev_priv | output | 2 | Value for the previous-privilege field |
| resv_clear | output | 1 | Drop any load reservation |

## Verification
The bench sweeps every mix of pending and delegation bits on four lines, at each privilege level and every setting of the three enable bits. A design that ignored a global-enable rule would trap out of privilege 3 with interrupts masked, or take a delegated line while in machine mode. A design that searched from the wrong end would report the highest eligible index.

Exception codes run over the full 0..63 range with delegation fully set. A design without the below-XLEN test would send codes 32 and above to supervisor level. Exceptions are also raised together with pending interrupts, which exposes any design where an interrupt wins. Traps with and without a faulting address show a design that strobes the bad-address register when it should not.

// File: rtl/trapc_pkg.sv
package trapc_pkg;
   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;
endpackage

// File: rtl/trapc_irq_pick.sv
module trapc_irq_pick #(
   parameter int NIRQ = 16,
   localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
   input  logic [NIRQ-1:0] cand,
   input  logic [NIRQ-1:0] deleg,
   input  logic [1:0]      priv,
   input  logic            sie,
   input  logic            mie,
   output logic            hit,
   output logic [IW-1:0]   idx,
   output logic            idx_deleg
);
   import trapc_pkg::*;
   logic m_ok, s_ok;
   logic [NIRQ-1:0] elig;

   // global-enable rules per handling level
   assign m_ok = (priv != PRIV_M) || mie;
   assign s_ok = (priv == PRIV_U) || ((priv == PRIV_S) && sie);
   assign elig = cand & ((~deleg & {NIRQ{m_ok}}) | (deleg & {NIRQ{s_ok}}));

   // lowest set index wins: scan downward so the last hit is the smallest
   always_comb begin
      hit = 1'b0;
      idx = '0;
      idx_deleg = 1'b0;
      for (int i = NIRQ - 1; i >= 0; i--) begin
         if (elig[i]) begin
            hit = 1'b1;
            idx = IW'(i);
            idx_deleg = deleg[i];
         end
      end
   end
endmodule

// File: rtl/trapc_route.sv
module trapc_route #(
   parameter int XLEN = 32,
   parameter int ECW  = 6,
   parameter int IW   = 4,
   localparam int XW  = $clog2(XLEN)
) (
   input  logic [1:0]      priv,
   input  logic            exc_valid,
   input  logic [ECW-1:0]  exc_code,
   input  logic [XLEN-1:0] exc_deleg,
   input  logic            irq_hit,
   input  logic [IW-1:0]   irq_idx,
   input  logic            irq_deleg,
   output logic            taken,
   output logic            to_s,
   output logic [XLEN-1:0] cause
);
   import trapc_pkg::*;
   logic code_in_range, exc_del, low_priv;

   generate
      if (ECW > XW) begin : g_wide_code
         assign code_in_range = (exc_code < ECW'(XLEN));
         assign exc_del = exc_deleg[exc_code[XW-1:0]];
      end else begin : g_narrow_code
         assign code_in_range = 1'b1;
         assign exc_del = exc_deleg[XW'(exc_code)];
      end
   endgenerate

   assign low_priv = (priv == PRIV_U) || (priv == PRIV_S);

   always_comb begin
      taken = exc_valid || irq_hit;
      if (exc_valid) begin
         cause = {{(XLEN-ECW){1'b0}}, exc_code};
         to_s  = low_priv && code_in_range && exc_del;
      end else begin
         cause = {1'b1, {(XLEN-1-IW){1'b0}}, irq_idx};
         to_s  = low_priv && irq_hit && irq_deleg;
      end
   end
endmodule

// File: rtl/trapc_top.sv
module trapc_top #(
   parameter int XLEN = 32,
   parameter int NIRQ = 16,
   parameter int ECW  = 6,
   localparam int IW  = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      cur_priv,
   input  logic            st_uie,
   input  logic            st_sie,
   input  logic            st_mie,
   input  logic [NIRQ-1:0] irq_pend,
   input  logic [NIRQ-1:0] irq_en,
   input  logic [NIRQ-1:0] irq_deleg,
   input  logic [XLEN-1:0] exc_deleg,
   input  logic [XLEN-1:0] stvec,
   input  logic [XLEN-1:0] mtvec,
   input  logic            exc_valid,
   input  logic [ECW-1:0]  exc_code,
   input  logic            exc_has_bad,
   input  logic [XLEN-1:0] exc_badaddr,
   input  logic [XLEN-1:0] fault_pc,
   output logic            trap_taken,
   output logic [XLEN-1:0] redirect_pc,
   output logic [1:0]      next_priv,
   output logic [XLEN-1:0] cause_out,
   output logic [XLEN-1:0] epc_out,
   output logic [XLEN-1:0] badaddr_out,
   output logic            s_csr_wr,
   output logic            m_csr_wr,
   output logic            s_bad_wr,
   output logic            m_bad_wr,
   output logic            prev_ie,
   output logic [1:0]      prev_priv,
   output logic            resv_clear
);
   import trapc_pkg::*;

   generate
      if (NIRQ < 1 || NIRQ > XLEN - 1) begin : g_bad_nirq
         $error("NIRQ must lie in 1..XLEN-1");
      end
      if (ECW < 1 || ECW >= XLEN) begin : g_bad_ecw
         $error("ECW must lie in 1..XLEN-1");
      end
      if (XLEN < 8) begin : g_bad_xlen
         $error("XLEN too small");
      end
   endgenerate

   logic            irq_hit, irq_del, taken, to_s, old_ie, bad_now;
   logic [IW-1:0]   irq_idx;
   logic [XLEN-1:0] cause;

   trapc_irq_pick #(.NIRQ(NIRQ)) u_pick (
      .cand(irq_pend & irq_en), .deleg(irq_deleg), .priv(cur_priv),
      .sie(st_sie), .mie(st_mie), .hit(irq_hit), .idx(irq_idx),
      .idx_deleg(irq_del)
   );

   trapc_route #(.XLEN(XLEN), .ECW(ECW), .IW(IW)) u_route (
      .priv(cur_priv), .exc_valid(exc_valid), .exc_code(exc_code),
      .exc_deleg(exc_deleg), .irq_hit(irq_hit), .irq_idx(irq_idx),
      .irq_deleg(irq_del), .taken(taken), .to_s(to_s), .cause(cause)
   );

   always_comb begin
      case (cur_priv)
         PRIV_U:  old_ie = st_uie;
         PRIV_S:  old_ie = st_sie;
         default: old_ie = st_mie;
      endcase
   end
   assign bad_now = exc_valid && exc_has_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_taken  <= 1'b0;
         redirect_pc <= '0;
         next_priv   <= PRIV_M;
         cause_out   <= '0;
         epc_out     <= '0;
         badaddr_out <= '0;
         s_csr_wr    <= 1'b0;
         m_csr_wr    <= 1'b0;
         s_bad_wr    <= 1'b0;
         m_bad_wr    <= 1'b0;
         prev_ie     <= 1'b0;
         prev_priv   <= PRIV_U;
         resv_clear  <= 1'b0;
      end else begin
         trap_taken  <= taken;
         resv_clear  <= taken;
         s_csr_wr    <= taken && to_s;
         m_csr_wr    <= taken && !to_s;
         s_bad_wr    <= taken && to_s && bad_now;
         m_bad_wr    <= taken && !to_s && bad_now;
         redirect_pc <= to_s ? stvec : mtvec;
         next_priv   <= to_s ? PRIV_S : PRIV_M;
         cause_out   <= cause;
         epc_out     <= fault_pc;
         badaddr_out <= exc_badaddr;
         prev_ie     <= old_ie;
         prev_priv   <= cur_priv;
      end
   end
endmodule

// File: rtl/trapc_chk.sv
module trapc_chk #(
   parameter int XLEN = 32,
   parameter int NIRQ = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NIRQ-1:0] irq_pend,
   input logic [NIRQ-1:0] irq_en,
   input logic            exc_valid,
   input logic [XLEN-1:0] stvec,
   input logic [XLEN-1:0] mtvec,
   input logic            trap_taken,
   input logic [XLEN-1:0] redirect_pc,
   input logic [1:0]      next_priv,
   input logic [XLEN-1:0] cause_out,
   input logic            s_csr_wr,
   input logic            m_csr_wr,
   input logic            s_bad_wr,
   input logic            m_bad_wr,
   input logic            resv_clear
);
   assert_no_candidate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (((irq_pend & irq_en) == '0) && !exc_valid) |=> !trap_taken);

   assert_single_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({s_csr_wr, m_csr_wr}));

   assert_s_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      s_csr_wr |-> (next_priv == 2'd1 && redirect_pc == $past(stvec)));

   assert_m_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      m_csr_wr |-> (next_priv == 2'd3 && redirect_pc == $past(mtvec)));

   assert_bad_in_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bad_wr || m_bad_wr) |-> trap_taken);

   assert_exc_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> (trap_taken && !cause_out[XLEN-1]));

   assert_resv_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      trap_taken |-> (resv_clear && (s_csr_wr || m_csr_wr)));
endmodule

bind trapc_top trapc_chk #(.XLEN(XLEN), .NIRQ(NIRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
   .exc_valid(exc_valid), .stvec(stvec), .mtvec(mtvec),
   .trap_taken(trap_taken), .redirect_pc(redirect_pc), .next_priv(next_priv),
   .cause_out(cause_out), .s_csr_wr(s_csr_wr), .m_csr_wr(m_csr_wr),
   .s_bad_wr(s_bad_wr), .m_bad_wr(m_bad_wr), .resv_clear(resv_clear)
);

// File: tb/tb_trapc_top.sv
`timescale 1ns/1ps
module tb_trapc_top;
   localparam int XLEN = 32;
   localparam int NIRQ = 4;
   localparam int ECW  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [1:0] cur_priv = 2'd3;
   logic st_uie = 0, st_sie = 0, st_mie = 0;
   logic [NIRQ-1:0] irq_pend = '0, irq_en = '0, irq_deleg = '0;
   logic [XLEN-1:0] exc_deleg = '0;
   logic [XLEN-1:0] stvec = 32'h0000_8100, mtvec = 32'h0000_4200;
   logic exc_valid = 0, exc_has_bad = 0;
   logic [ECW-1:0] exc_code = '0;
   logic [XLEN-1:0] exc_badaddr = 32'hDEAD_0000, fault_pc = 32'h0000_1000;

   logic trap_taken, s_csr_wr, m_csr_wr, s_bad_wr, m_bad_wr, prev_ie, resv_clear;
   logic [XLEN-1:0] redirect_pc, cause_out, epc_out, badaddr_out;
   logic [1:0] next_priv, prev_priv;

   trapc_top #(.XLEN(XLEN), .NIRQ(NIRQ), .ECW(ECW)) dut (.*);

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   // independent reference model
   logic e_taken, e_tos, e_irq, e_ie;
   int   e_num;
   task automatic model();
      logic del;
      e_taken = 0; e_irq = 0; e_num = 0; del = 0;
      if (exc_valid) begin
         e_taken = 1; e_num = int'(exc_code);
         del = (e_num < XLEN) ? exc_deleg[e_num % XLEN] : 1'b0;
      end else begin
         for (int i = 0; i < NIRQ; i++) begin
            logic ok;
            if (irq_deleg[i]) ok = (cur_priv == 0) || (cur_priv == 1 && st_sie);
            else              ok = (cur_priv != 3) || st_mie;
            if (!e_taken && irq_pend[i] && irq_en[i] && ok) begin
               e_taken = 1; e_irq = 1; e_num = i; del = irq_deleg[i];
            end
         end
      end
      e_tos = e_taken && (cur_priv <= 1) && del;
      e_ie = (cur_priv == 0) ? st_uie : (cur_priv == 1) ? st_sie : st_mie;
   endtask

   task automatic step_check(input string ph);
      logic [XLEN-1:0] ecause;
      logic bad;
      model();
      @(posedge clk); #1;
      ecause = e_irq ? (32'h8000_0000 | XLEN'(e_num)) : XLEN'(e_num);
      bad = exc_valid && exc_has_bad;
      chk({ph, " R1 R2 R3 R10 taken"}, trap_taken, e_taken);
      if (e_taken) begin
         chk({ph, " R4 R5 cause"}, cause_out, ecause);
         chk({ph, " R6 to_s"}, s_csr_wr, e_tos);
         if (e_tos) begin
            chk({ph, " R7 pc"}, redirect_pc, stvec);
            chk({ph, " R7 priv"}, next_priv, 2'd1);
         end else begin
            chk({ph, " R8 pc"}, redirect_pc, mtvec);
            chk({ph, " R8 priv"}, next_priv, 2'd3);
            chk({ph, " R8 mwr"}, m_csr_wr, 1'b1);
         end
         chk({ph, " R9 epc"}, epc_out, fault_pc);
         chk({ph, " R9 pie"}, prev_ie, e_ie);
         chk({ph, " R9 pp"}, prev_priv, cur_priv);
         chk({ph, " R9 sbad"}, s_bad_wr, e_tos && bad);
         chk({ph, " R9 mbad"}, m_bad_wr, !e_tos && bad);
         if (bad) chk({ph, " R9 badaddr"}, badaddr_out, exc_badaddr);
         chk({ph, " R11 resv"}, resv_clear, 1'b1);
      end else begin
         chk({ph, " R11 idle"}, {s_csr_wr, m_csr_wr, s_bad_wr, m_bad_wr, resv_clear}, 5'b0);
      end
   endtask

   initial begin
      // reset with traps requested: nothing may come out (R12)
      exc_valid = 1; irq_pend = '1; irq_en = '1;
      repeat (3) @(posedge clk);
      #1;
      chk("R12 reset taken", trap_taken, 1'b0);
      chk("R12 reset strobes", {s_csr_wr, m_csr_wr, s_bad_wr, m_bad_wr, resv_clear}, 5'b0);
      @(negedge clk);
      exc_valid = 0; irq_pend = '0; rst_n = 1;

      // interrupt sweep
      for (int pi = 0; pi < 3; pi++)
         for (int st = 0; st < 8; st++)
            for (int ei = 0; ei < 2; ei++)
               for (int pd = 0; pd < 16; pd++)
                  for (int dl = 0; dl < 16; dl++) begin
                     @(negedge clk);
                     cur_priv = (pi == 2) ? 2'd3 : 2'(pi);
                     {st_uie, st_sie, st_mie} = 3'(st);
                     irq_en = ei ? 4'b0101 : 4'b1111;
                     irq_pend = 4'(pd);
                     irq_deleg = 4'(dl);
                     fault_pc = 32'h1000 + 32'(pd * 4);
                     step_check("irq");
                  end

      // exception sweep, codes above XLEN included, with and without interrupts
      for (int pi = 0; pi < 3; pi++)
         for (int code = 0; code < 64; code++)
            for (int v = 0; v < 8; v++) begin
               @(negedge clk);
               cur_priv = (pi == 2) ? 2'd3 : 2'(pi);
               {st_uie, st_sie, st_mie} = 3'(code % 8);
               exc_valid = 1;
               exc_code = 6'(code);
               exc_deleg = v[0] ? 32'hFFFF_FFFF : 32'h0000_A5A5;
               exc_has_bad = v[1];
               irq_pend = v[2] ? 4'b1111 : 4'b0000;
               irq_en = 4'b1111;
               irq_deleg = 4'b0011;
               exc_badaddr = 32'hBAD0_0000 | 32'(code);
               step_check("exc");
            end

      // return to idle: nothing pending
      @(negedge clk);
      exc_valid = 0; irq_pend = '0;
      step_check("idle");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired R11");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule